// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This unit sits between the pins of a small programmable logic device and its product-term array and output macrocells. One pin has two possible roles. When a configuration bit selects power-down, that pin becomes a sleep control. When the configuration bit does not select it, the pin is an ordinary logic input to the array.

With sleep selected and the pin high, the unit freezes the device. The array stops seeing changes on any other input. Every macrocell register keeps its state, and every output keeps both its value and its enable, whether the output is registered or combinational. An output that was disabled when sleep began stays disabled.

When the pin falls, the input gates reopen at once and outputs follow live logic again. The next clock edge loads the registers from the sum terms that the new inputs produce. Weak hold latches on the dedicated and I/O inputs keep the last driven level of any pin that is no longer driven.

Top module: `pd_hold_unit`

## Requirements
- R1: With `pd_en` low, `pd_active` stays low whatever `pd_pin` does, `arr_shared` equals `pd_pin`, and all outputs track live logic.
- R2: With `pd_en` high, `arr_shared` reads 0, and `pd_active` equals `pd_pin`.
- R3: While `pd_active` is high, `arr_ded` and `arr_io` keep the values they had when it rose, whatever the pins do.
- R4: While `pd_active` is high, clock edges leave `arr_fb` (the register state) unchanged.
- R5: While `pd_active` is high, `out_val` keeps the value it had when sleep began, for both registered and combinational macrocells.
- R6: While `pd_active` is high, `out_oe` is held as well, so an output with enable 0 at entry stays 0 even when `oe_d` rises.
- R7: When `pd_active` falls, the array inputs and outputs follow live values in the same cycle. Each later rising clock edge with `pd_active` low loads `arr_fb` with `sum_d`.
- R8: A dedicated or I/O input whose drive bit (`in_drv`/`io_drv`) is 0 presents the last level seen while its drive bit was 1.
- R9: `rst_n` low clears `arr_fb` to all zeros at once, without waiting for a clock edge.
- R10: For each macrocell, the live output value is taken from the register bit when `mc_reg` is 1 and from `sum_d` when it is 0. That value is inverted when `mc_inv` is 1, and `out_oe` follows `oe_d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| pd_en | input | 1 | Configuration: shared pin acts as sleep control |
| pd_pin | input | 1 | Shared sleep/logic pin |
| in_pin | input | N_IN | Dedicated input pin levels |
| in_drv | input | N_IN | 1 where a dedicated pin is actively driven |
| io_pin | input | N_MC | I/O pin levels |
| io_drv | input | N_MC | 1 where an I/O pin is actively driven |
| sum_d | input | N_MC | Sum-term result from the array, one per macrocell |
| oe_d | input | N_MC | Output enable term per macrocell |
| mc_reg | input | N_MC | Macrocell mode: 1 registered, 0 combinational |
| mc_inv | input | N_MC | Macrocell output inversion |
| arr_ded | output | N_IN | Gated dedicated inputs to the array |
| arr_shared | output | 1 | Shared pin as an array input |
| arr_io | output | N_MC | Gated I/O pin inputs to the array |
| arr_fb | output | N_MC | Register feedback to the array |
| out_val | output | N_MC | Held output values |
| out_oe | output | N_MC | Held output enables |
| pd_active | output | 1 | Sleep currently in force |

## Verification
A register that moves during sleep shows up on `arr_fb` at the first clock edge inside the sleep window. It shows up on `out_val` only after release, when the frozen value no longer hides it. A hold latch that stays transparent lets pin or sum-term changes reach `arr_ded`, `arr_io` or `out_val` in the same cycle they are applied. A latch that fails to reopen leaves stale values on those ports in the first cycle after release. A wrong keeper state appears on the array inputs as soon as a drive bit drops and the pin level changes.

// File: rtl/pd_hold_unit.sv
module pd_hold_unit #(
  parameter int N_IN = 11,
  parameter int N_MC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_en,
  input  logic            pd_pin,
  input  logic [N_IN-1:0] in_pin,
  input  logic [N_IN-1:0] in_drv,
  input  logic [N_MC-1:0] io_pin,
  input  logic [N_MC-1:0] io_drv,
  input  logic [N_MC-1:0] sum_d,
  input  logic [N_MC-1:0] oe_d,
  input  logic [N_MC-1:0] mc_reg,
  input  logic [N_MC-1:0] mc_inv,
  output logic [N_IN-1:0] arr_ded,
  output logic            arr_shared,
  output logic [N_MC-1:0] arr_io,
  output logic [N_MC-1:0] arr_fb,
  output logic [N_MC-1:0] out_val,
  output logic [N_MC-1:0] out_oe,
  output logic            pd_active
);

  logic [N_IN-1:0] in_keep, ded_h;
  logic [N_MC-1:0] io_keep, io_h, fb_q, live_val, val_h, oe_h;

  assign pd_active  = pd_en & pd_pin;
  assign arr_shared = ~pd_en & pd_pin;

  always_latch begin
    for (int i = 0; i < N_IN; i++)
      if (in_drv[i]) in_keep[i] = in_pin[i];
  end

  always_latch begin
    for (int i = 0; i < N_MC; i++)
      if (io_drv[i]) io_keep[i] = io_pin[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fb_q <= '0;
    else if (!pd_active) fb_q <= sum_d;
  end

  assign live_val = ((mc_reg & fb_q) | (~mc_reg & sum_d)) ^ mc_inv;

  always_latch begin
    if (!pd_active) begin
      ded_h = in_keep;
      io_h  = io_keep;
      val_h = live_val;
      oe_h  = oe_d;
    end
  end

  assign arr_ded = ded_h;
  assign arr_io  = io_h;
  assign arr_fb  = fb_q;
  assign out_val = val_h;
  assign out_oe  = oe_h;

endmodule

module pd_hold_chk #(
  parameter int N_IN = 11,
  parameter int N_MC = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pd_en,
  input logic            pd_pin,
  input logic            pd_active,
  input logic            arr_shared,
  input logic [N_IN-1:0] arr_ded,
  input logic [N_MC-1:0] arr_io,
  input logic [N_MC-1:0] arr_fb,
  input logic [N_MC-1:0] out_val,
  input logic [N_MC-1:0] out_oe,
  input logic [N_MC-1:0] sum_d
);

  // R1
  shared_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_en |-> (!pd_active && arr_shared == pd_pin));

  // R2
  shared_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_en |-> !arr_shared);

  // R3
  in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_active) && pd_active) |-> ($stable(arr_ded) && $stable(arr_io)));

  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_active) && $past(rst_n)) |-> $stable(arr_fb));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_active) && pd_active) |-> $stable(out_val));

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_active) && pd_active) |-> ((out_oe & ~$past(out_oe)) == '0));

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!pd_active) && $past(rst_n)) |-> (arr_fb == $past(sum_d)));

endmodule

bind pd_hold_unit pd_hold_chk #(.N_IN(N_IN), .N_MC(N_MC)) u_pd_hold_chk (
  .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .pd_pin(pd_pin),
  .pd_active(pd_active), .arr_shared(arr_shared), .arr_ded(arr_ded),
  .arr_io(arr_io), .arr_fb(arr_fb), .out_val(out_val), .out_oe(out_oe),
  .sum_d(sum_d)
);

// File: tb/test_pd_hold_unit.sv
module test_pd_hold_unit;
  localparam int N_IN = 11;
  localparam int N_MC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pd_en = 1'b0, pd_pin = 1'b0;
  logic [N_IN-1:0] in_pin = '0, in_drv = '1;
  logic [N_MC-1:0] io_pin = '0, io_drv = '1, sum_d = '0, oe_d = '0, mc_reg = '0, mc_inv = '0;
  logic [N_IN-1:0] arr_ded;
  logic            arr_shared, pd_active;
  logic [N_MC-1:0] arr_io, arr_fb, out_val, out_oe;

  logic n_rst, n_pd_en, n_pd_pin;
  logic [N_IN-1:0] n_in_pin, n_in_drv;
  logic [N_MC-1:0] n_io_pin, n_io_drv, n_sum, n_oe, n_reg, n_inv;

  logic [N_IN-1:0] kd, h_ded;
  logic [N_MC-1:0] ki, h_io, h_val, h_oe, mreg;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pd_hold_unit i_pd_hold_unit (
    .clk(clk), .rst_n(rst_n), .pd_en(pd_en), .pd_pin(pd_pin),
    .in_pin(in_pin), .in_drv(in_drv), .io_pin(io_pin), .io_drv(io_drv),
    .sum_d(sum_d), .oe_d(oe_d), .mc_reg(mc_reg), .mc_inv(mc_inv),
    .arr_ded(arr_ded), .arr_shared(arr_shared), .arr_io(arr_io), .arr_fb(arr_fb),
    .out_val(out_val), .out_oe(out_oe), .pd_active(pd_active)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) mreg <= '0;
    else if (!(pd_en && pd_pin)) mreg <= sum_d;

  function automatic logic [N_MC-1:0] model_live();
    logic [N_MC-1:0] v;
    for (int i = 0; i < N_MC; i++) begin
      v[i] = mc_reg[i] ? mreg[i] : sum_d[i];
      if (mc_inv[i]) v[i] = !v[i];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit pd = pd_en && pd_pin;
    chk(tag, "pd_active", 32'(pd_active), 32'(pd));
    chk(tag, "arr_shared", 32'(arr_shared), 32'(pd_en ? 1'b0 : pd_pin));
    chk(tag, "arr_ded", 32'(arr_ded), 32'(pd ? h_ded : kd));
    chk(tag, "arr_io", 32'(arr_io), 32'(pd ? h_io : ki));
    chk(tag, "arr_fb", 32'(arr_fb), 32'(mreg));
    chk(tag, "out_val", 32'(out_val), 32'(pd ? h_val : model_live()));
    chk(tag, "out_oe", 32'(out_oe), 32'(pd ? h_oe : oe_d));
  endtask

  task automatic cyc(input string tag);
    @(negedge clk);
    if (!(pd_en && pd_pin)) begin
      h_ded = kd; h_io = ki; h_val = model_live(); h_oe = oe_d;
    end
    rst_n = n_rst; pd_en = n_pd_en; pd_pin = n_pd_pin;
    in_pin = n_in_pin; in_drv = n_in_drv; io_pin = n_io_pin; io_drv = n_io_drv;
    sum_d = n_sum; oe_d = n_oe; mc_reg = n_reg; mc_inv = n_inv;
    for (int i = 0; i < N_IN; i++) if (in_drv[i]) kd[i] = in_pin[i];
    for (int i = 0; i < N_MC; i++) if (io_drv[i]) ki[i] = io_pin[i];
    #2 compare(tag);
  endtask

  task automatic shuffle();
    n_in_pin = N_IN'($urandom); n_io_pin = N_MC'($urandom);
    n_sum = N_MC'($urandom); n_oe = N_MC'($urandom);
  endtask

  initial begin
    kd = '0; ki = '0;
    n_rst = 0; n_pd_en = 0; n_pd_pin = 0;
    n_in_pin = 11'h5A3; n_in_drv = '1; n_io_pin = 10'h1C6; n_io_drv = '1;
    n_sum = 10'h3FF; n_oe = 10'h2AA; n_reg = 10'h2B5; n_inv = 10'h0F0;
    // R9 reset state: registers zero, registered outputs show inversion only
    repeat (3) cyc("R9");
    n_rst = 1;
    // R1 shared pin is plain logic when sleep is not configured
    for (int k = 0; k < 8; k++) begin shuffle(); n_pd_pin = k[0]; cyc("R1"); end
    // R2 sleep configured but idle
    n_pd_en = 1; n_pd_pin = 0;
    for (int k = 0; k < 4; k++) begin shuffle(); cyc("R2"); end
    // R6 some enables low at entry
    shuffle(); n_oe = 10'h0F3; cyc("R6");
    n_pd_pin = 1; n_oe = '1; shuffle(); n_oe = '1; cyc("R6");
    // R3 R4 R5 everything moves while asleep
    for (int k = 0; k < 8; k++) begin shuffle(); n_oe = '1; cyc("R3 R4 R5"); end
    // R7 release then normal loading
    n_pd_pin = 0;
    for (int k = 0; k < 5; k++) begin shuffle(); cyc("R7"); end
    // R8 undriven pins keep last level, also across sleep
    for (int k = 0; k < 10; k++) begin
      shuffle(); n_in_drv = N_IN'($urandom); n_io_drv = N_MC'($urandom);
      n_pd_pin = (k > 5); cyc("R8");
    end
    n_in_drv = '1; n_io_drv = '1; n_pd_pin = 0;
    // R10 mode and polarity per macrocell
    n_pd_en = 0;
    for (int k = 0; k < 8; k++) begin
      shuffle(); n_reg = N_MC'($urandom); n_inv = N_MC'($urandom); cyc("R10");
    end
    // R9 asynchronous clear mid-run
    n_rst = 0; shuffle(); cyc("R9");
    n_rst = 1; shuffle(); cyc("R9");
    for (int k = 0; k < 3; k++) begin shuffle(); cyc("R7"); end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule